// File: doc/BRIEF.md
# Variable-Length Codeword Bitstream Packer

The block takes one variable-length codeword per cycle and joins the codewords into a continuous bitstream. Each codeword arrives left-aligned in a 13-bit field with a length. An optional sign bit can be placed directly after the codeword bits. The joined stream leaves the block as 32-bit words, most significant bit first. Bits that do not yet fill a word stay in a residual register until later codewords complete it.

A small state machine controls the block. After reset it sits in `ST_IDLE` and ignores its inputs. A `start` pulse moves it to `ST_RUN` (transition *arm*). In `ST_RUN` it accepts codewords, and a `flush` request moves it to `ST_DRAIN` (transition *drain*). `ST_DRAIN` lasts one cycle. In that cycle the block pads any pending bits with zeros, emits them as a final word, clears the residual and count, and returns to `ST_RUN` (transition *resume*). Reset returns the block to `ST_IDLE` from any state (transition *clear*).

The held bit count is a 5-bit accumulator. When adding a codeword's length makes the count reach 32 or more, the carry out of the accumulator is what raises the word strobe.

Top module: `cw_packer`

## Requirements
- R1: After reset, `in_ready`, `out_valid` and `out_word` are 0. In `ST_IDLE`, codewords presented on the inputs are ignored and no word is emitted until `start` is seen.
- R2: `in_ready` is 1 exactly while the block is in `ST_RUN`. A codeword is accepted in a cycle where `in_valid` and `in_ready` are both 1.
- R3: Only the top `in_len` bits of `in_code` are appended, starting with bit 12. The lower bits of `in_code` have no effect on the stream.
- R4: When `in_sign_en` is 1, the value of `in_sign` is appended as one extra bit directly after the codeword bits.
- R5: The first appended bit after start, flush or reset lands in bit 31 of the next word. When the held count plus the appended length reaches 32 or more, `out_word` carries the completed word and `out_valid` pulses for one cycle. Both appear in the cycle after the accepting edge.
- R6: Bits beyond a word boundary are kept in order and begin the next word. No bit is lost or duplicated across words.
- R7: A `flush` in `ST_RUN` moves the block to `ST_DRAIN` for one cycle, and `in_ready` is 0 during that cycle. In the cycle after the `ST_DRAIN` cycle, the pending bits, if there are any, appear as one word padded below with zeros. If nothing is pending, no word is emitted. The count is then zero.
- R8: A codeword accepted in the same cycle as `flush` is appended before the padding. If it completes a word, that word is emitted first and the remaining bits come out in the padded word.
- R9: Reset during operation discards all pending bits and returns the block to `ST_IDLE`.
- R10: A length of 0 appends no codeword bits. With `in_sign_en` set, only the sign bit is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Arms packing from `ST_IDLE` |
| in_valid | input | 1 | Codeword present |
| in_ready | output | 1 | Block accepts codewords (`ST_RUN`) |
| in_code | input | 13 | Left-aligned codeword, bit 12 sent first |
| in_len | input | 4 | Number of codeword bits, 0 to 13 |
| in_sign_en | input | 1 | Append a sign bit after the codeword |
| in_sign | input | 1 | Sign bit value |
| flush | input | 1 | Pad and emit the pending bits |
| out_word | output | 32 | Packed word, bit 31 first in stream order |
| out_valid | output | 1 | One-cycle strobe for a new `out_word` |

## Verification
A codeword accepted at one clock edge produces its completed word one cycle later. A padded flush word comes two cycles after the `flush` edge, because the `ST_DRAIN` cycle lies in between. The bench drives each input just after a falling edge and lets exactly one rising edge pass. It then checks `out_valid` and `out_word` at the following falling edge against a bit-queue model. The model has already been advanced by that cycle's stimulus, including whether the model is idle, running or draining. `in_ready` is checked before every drive. This catches a word that arrives a cycle early or late, as well as a wrong bit.

// File: rtl/cw_packer_pkg.sv
package cw_packer_pkg;
    localparam int unsigned PK_WORD_W = 32;
    localparam int unsigned PK_CODE_W = 13;
    localparam int unsigned PK_LEN_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } pk_state_t;
endpackage

// File: rtl/cw_field.sv
// Forms the left-aligned field of one cycle: codeword bits then optional sign.
module cw_field #(
    parameter int unsigned CODE_W = 13,
    parameter int unsigned LEN_W  = 4,
    localparam int unsigned FLD_W = CODE_W + 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic [LEN_W-1:0]  len,
    input  logic              sign_en,
    input  logic              sign,
    output logic [FLD_W-1:0]  field,
    output logic [LEN_W:0]    flen
);
    logic [CODE_W-1:0] keep;
    logic [FLD_W-1:0]  sign_pos;

    always_comb begin
        keep     = ~({CODE_W{1'b1}} >> len);
        sign_pos = {1'b1, {CODE_W{1'b0}}} >> len;
        field    = {code & keep, 1'b0};
        if (sign_en && sign) begin
            field = field | sign_pos;
        end
        flen = {1'b0, len} + {{LEN_W{1'b0}}, sign_en};
    end
endmodule

// File: rtl/cw_merge.sv
// Appends a field below the held bits and splits off a full word on carry.
module cw_merge #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned FLD_W  = 14,
    parameter int unsigned FLEN_W = 5,
    localparam int unsigned CNT_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] resid,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [FLD_W-1:0]  field,
    input  logic [FLEN_W-1:0] flen,
    output logic [WORD_W-1:0] full_word,
    output logic [WORD_W-1:0] next_resid,
    output logic [CNT_W-1:0]  next_cnt,
    output logic              carry
);
    localparam int unsigned WIDE_W = 2 * WORD_W;

    logic [WIDE_W-1:0] placed;
    logic [WIDE_W-1:0] wide;
    logic [CNT_W:0]    sum;

    always_comb begin
        placed     = {field, {(WIDE_W-FLD_W){1'b0}}} >> cnt;
        wide       = {resid, {WORD_W{1'b0}}} | placed;
        sum        = {1'b0, cnt} + (CNT_W+1)'(flen);
        carry      = sum[CNT_W];
        next_cnt   = sum[CNT_W-1:0];
        full_word  = wide[WIDE_W-1:WORD_W];
        next_resid = carry ? wide[WORD_W-1:0] : wide[WIDE_W-1:WORD_W];
    end
endmodule

// File: rtl/cw_packer.sv
module cw_packer
    import cw_packer_pkg::*;
#(
    parameter int unsigned WORD_W = PK_WORD_W,
    parameter int unsigned CODE_W = PK_CODE_W,
    parameter int unsigned LEN_W  = PK_LEN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_code,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_sign_en,
    input  logic              in_sign,
    input  logic              flush,
    output logic [WORD_W-1:0] out_word,
    output logic              out_valid
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam int unsigned FLD_W = CODE_W + 1;

    pk_state_t state, state_nxt;

    logic [WORD_W-1:0] resid;
    logic [CNT_W-1:0]  cnt;
    logic [FLD_W-1:0]  field;
    logic [LEN_W:0]    flen;
    logic [WORD_W-1:0] m_word;
    logic [WORD_W-1:0] m_resid;
    logic [CNT_W-1:0]  m_cnt;
    logic              m_carry;
    logic              accept;

    cw_field #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_field (
        .code    (in_code),
        .len     (in_len),
        .sign_en (in_sign_en),
        .sign    (in_sign),
        .field   (field),
        .flen    (flen)
    );

    cw_merge #(.WORD_W(WORD_W), .FLD_W(FLD_W), .FLEN_W(LEN_W+1)) u_merge (
        .resid      (resid),
        .cnt        (cnt),
        .field      (field),
        .flen       (flen),
        .full_word  (m_word),
        .next_resid (m_resid),
        .next_cnt   (m_cnt),
        .carry      (m_carry)
    );

    assign in_ready = (state == ST_RUN);
    assign accept   = in_ready && in_valid;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start) state_nxt = ST_RUN;
            ST_RUN:   if (flush) state_nxt = ST_DRAIN;
            ST_DRAIN: state_nxt = ST_RUN;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            resid     <= '0;
            cnt       <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (accept) begin
                resid <= m_resid;
                cnt   <= m_cnt;
                if (m_carry) begin
                    out_word  <= m_word;
                    out_valid <= 1'b1;
                end
            end else if (state == ST_DRAIN) begin
                if (cnt != '0) begin
                    out_word  <= resid;
                    out_valid <= 1'b1;
                end
                resid <= '0;
                cnt   <= '0;
            end
        end
    end

    // R5
    word_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (({1'b0, cnt} + (CNT_W+1)'(flen)) >= (CNT_W+1)'(WORD_W))) |=> out_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> !out_valid);

    // R7
    drain_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |=> (cnt == '0 && state == ST_RUN));

    // R6
    resid_clean_chk: assert property (@(posedge clk) disable iff (rst)
        ((resid << cnt) == '0));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        $fell(rst) |-> (state == ST_IDLE && cnt == '0 && !out_valid));
endmodule

// File: tb/cw_packer_bench.sv
module cw_packer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [12:0] in_code = '0;
    logic [3:0]  in_len = '0;
    logic        in_sign_en = 1'b0;
    logic        in_sign = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] out_word;
    logic        out_valid;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit q[$];
    bit m_run = 0;
    bit m_drain = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cw_packer u_cw_packer (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
        .in_ready(in_ready), .in_code(in_code), .in_len(in_len),
        .in_sign_en(in_sign_en), .in_sign(in_sign), .flush(flush),
        .out_word(out_word), .out_valid(out_valid)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "watchdog", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input logic v, input logic [12:0] c, input logic [3:0] l,
                        input logic se, input logic s, input logic f, input string tag);
        bit ev = 0;
        logic [31:0] ew = '0;
        chk(in_ready == (m_run && !m_drain), "R2 in_ready", 32'(in_ready), 32'(m_run && !m_drain));
        in_valid = v; in_code = c; in_len = l; in_sign_en = se; in_sign = s; flush = f;
        if (m_drain) begin
            if (q.size() > 0) begin
                ev = 1;
                for (int i = 0; i < 32; i++) ew[31-i] = (q.size() > 0) ? q.pop_front() : 1'b0;
            end
            m_drain = 0;
        end else if (m_run) begin
            if (v) begin
                for (int i = 0; i < int'(l); i++) q.push_back(c[12-i]);
                if (se) q.push_back(s);
            end
            if (q.size() >= 32) begin
                ev = 1;
                for (int i = 0; i < 32; i++) ew[31-i] = q.pop_front();
            end
            if (f) m_drain = 1;
        end
        @(posedge clk); @(negedge clk);
        in_valid = 0; flush = 0;
        chk(out_valid == ev, {tag, " out_valid"}, 32'(out_valid), 32'(ev));
        if (ev) chk(out_word == ew, {tag, " out_word"}, out_word, ew);
    endtask

    task automatic do_start();
        start = 1;
        @(posedge clk); @(negedge clk);
        start = 0;
        m_run = 1;
    endtask

    task automatic do_flush(input string tag);
        step(0, '0, '0, 0, 0, 1, tag);
        step(0, '0, '0, 0, 0, 0, tag);
    endtask

    initial begin
        process::self().srandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(out_valid == 0, "R1 reset out_valid", 32'(out_valid), 0);
        chk(out_word == 0, "R1 reset out_word", out_word, 0);
        chk(in_ready == 0, "R1 reset in_ready", 32'(in_ready), 0);
        // R1 codewords ignored while idle
        for (int k = 0; k < 6; k++) step(1, 13'h1FFF, 4'd13, 1, 1, 0, "R1");
        do_start();
        // R5 exact fill from bit 31
        for (int k = 0; k < 4; k++) step(1, {8'hA5 + 8'(k), 5'b0}, 4'd8, 0, 0, 0, "R5");
        // R3 lower garbage ignored
        for (int k = 0; k < 12; k++) step(1, 13'h1FFF ^ 13'(k), 4'd3, 0, 0, 0, "R3");
        // R4 sign bit after codeword
        for (int k = 0; k < 8; k++) step(1, 13'h0AAA, 4'd5, 1, k[0], 0, "R4");
        // R10 zero length
        for (int k = 0; k < 10; k++) step(1, 13'h1FFF, 4'd0, k[0], 1, 0, "R10");
        // R7 flush with pending bits, then empty flush
        do_flush("R7");
        do_flush("R7");
        // R8 flush together with a codeword crossing the boundary
        step(1, 13'h1234, 4'd13, 1, 1, 0, "R8");
        step(1, 13'h0F0F, 4'd13, 1, 0, 0, "R8");
        step(1, 13'h1ABC, 4'd13, 1, 1, 1, "R8");
        step(0, '0, '0, 0, 0, 0, "R8");
        // R6 random stream with occasional flush
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] l = 4'($urandom_range(1, 13));
            step($urandom_range(0, 7) != 0, 13'($urandom), l, 1'($urandom), 1'($urandom),
                 $urandom_range(0, 39) == 0, "R6");
        end
        // R9 reset mid-stream
        step(1, 13'h1555, 4'd13, 1, 1, 0, "R9");
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0;
        q.delete(); m_run = 0; m_drain = 0;
        chk(in_ready == 0, "R9 idle after reset", 32'(in_ready), 0);
        do_start();
        for (int k = 0; k < 8; k++) step(1, 13'h0C31, 4'd7, 1, 0, 0, "R9");
        do_flush("R9");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule